// File: doc/BRIEF.md
# Tap Event Window Timer

This block measures the span of time in which a full tap event, single or double, has to complete. An upstream tap detector delivers one-cycle pulses on `tap_in`. The first pulse seen while the timer is idle opens a window. A second pulse inside that window ends it at once with a double-tap report. If the window runs out with no second pulse, a single-tap report is issued at that moment. A single tap is therefore never reported when the tap itself arrives.

The window length sits in an 8-bit read/write register that resets to 0xA0, which is about 0.4 s at the lowest tap rates. Time advances only on `smp_stb`, the sample strobe of the tap data path. A prescaler turns strobes into window counts. The number of strobes per count follows the rate-select code, so the window keeps roughly the same real length at higher sample rates.

The controller has two states. In IDLE a tap with a nonzero register value takes the START transition to OPEN. From OPEN, a tap takes SECOND to IDLE and raises `double_tap`. If no tap comes, the last count takes EXPIRE to IDLE and raises `single_tap`.

Top module: `tapwin_timer`

## Requirements
- R1: After reset the window register reads 0xA0, and `win_open`, `single_tap` and `double_tap` are all low.
- R2: A write (`cfg_wr` high for one cycle) stores `cfg_wdata`, and `cfg_rdata` shows the stored value from the next cycle on.
- R3: While idle, a `tap_in` pulse with a nonzero register value opens the window: `win_open` is high from the cycle after the tap.
- R4: With rate code 0 (400 Hz or below), the window closes on the L-th strobe after it opens, where L is the register value.
- R5: With rate code 1 (800 Hz), the window closes on the 2·L-th strobe after it opens.
- R6: With rate code 2 (1600 Hz) and rate code 3, the window closes on the 4·L-th strobe after it opens.
- R7: A window that closes with no second tap gives a one-cycle `single_tap` pulse in the cycle after the closing strobe, when `win_open` drops. No single-tap report appears while the window is open.
- R8: A `tap_in` pulse while the window is open gives a one-cycle `double_tap` in the next cycle and closes the window in that same cycle. No `single_tap` follows for that event.
- R9: While the register holds 0, taps are ignored: the window stays closed and no report is issued.
- R10: Opening a window clears the prescaler. Any partial strobe count left over and any strobe in the opening cycle do not shorten the first count.
- R11: `single_tap` and `double_tap` are never high together, and each stays high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | One-cycle strobe per tap-rate sample |
| rate_sel | input | 2 | Rate code: 0 = 400 Hz or below, 1 = 800 Hz, 2 or 3 = 1600 Hz |
| cfg_wr | input | 1 | Write enable for the window register |
| cfg_wdata | input | 8 | Value to write into the window register |
| cfg_rdata | output | 8 | Current window register value |
| tap_in | input | 1 | Tap pulse from the detector |
| win_open | output | 1 | High while a window is running |
| single_tap | output | 1 | One-cycle single-tap report |
| double_tap | output | 1 | One-cycle double-tap report |

## Verification
Every result appears one register stage after the edge that samples its cause. `win_open` rises, and `double_tap` pulses with `win_open` falling, in the cycle after the tap is sampled. `single_tap` and the drop of `win_open` come in the cycle after the closing strobe, and a written value is visible in the cycle after the write. The bench drives each stimulus for exactly one clock, samples one time unit after that edge, and counts strobes per test so it can check the window is still open before the closing strobe and closed just after it.

// File: rtl/tapwin_pkg.sv
package tapwin_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_OPEN = 1'b1
    } tw_state_e;

    typedef enum logic [1:0] {
        RATE_LOW  = 2'd0,
        RATE_MID  = 2'd1,
        RATE_HIGH = 2'd2,
        RATE_TOP  = 2'd3
    } tw_rate_e;

    // strobes that make one window count, per rate code
    function automatic int unsigned strobes_per_count(logic [1:0] code);
        int unsigned n;
        unique case (code)
            RATE_LOW:  n = 1;
            RATE_MID:  n = 2;
            default:   n = 4;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tapwin_cfg.sv
module tapwin_cfg #(
    parameter int unsigned   W       = 8,
    parameter logic [W-1:0]  RST_VAL = 8'hA0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] value
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= RST_VAL;
        else if (wr_en)
            value <= wr_data;
    end

endmodule

// File: rtl/tapwin_prescale.sv
module tapwin_prescale
    import tapwin_pkg::*;
#(
    parameter int unsigned MAX_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       run,
    input  logic       stb,
    input  logic [1:0] rate,
    output logic       tick
);

    localparam int unsigned PW = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

    logic [PW-1:0] cnt;
    logic [PW-1:0] last;

    always_comb begin
        last = PW'(strobes_per_count(rate) - 1);
        tick = run && stb && !clear && (cnt == last);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear || !run)
            cnt <= '0;
        else if (stb)
            cnt <= tick ? '0 : cnt + PW'(1);
    end

endmodule

// File: rtl/tapwin_fsm.sv
module tapwin_fsm
    import tapwin_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tap,
    input  logic [W-1:0] win_len,
    input  logic         tick,
    output logic         start,
    output logic         win_open,
    output logic         single_tap,
    output logic         double_tap
);

    tw_state_e    state, state_nx;
    logic [W-1:0] remain;
    logic         expire, second;

    always_comb begin
        state_nx = state;
        start    = 1'b0;
        expire   = 1'b0;
        second   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (tap && (win_len != '0)) begin
                    start    = 1'b1;
                    state_nx = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (tap) begin
                    second   = 1'b1;
                    state_nx = ST_IDLE;
                end else if (tick && (remain == W'(1))) begin
                    expire   = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // window count
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (start)
            remain <= win_len;
        else if ((state == ST_OPEN) && tick)
            remain <= remain - W'(1);
    end

    // report outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            single_tap <= 1'b0;
            double_tap <= 1'b0;
        end else begin
            single_tap <= expire;
            double_tap <= second;
        end
    end

    assign win_open = (state == ST_OPEN);

endmodule

// File: rtl/tapwin_timer.sv
module tapwin_timer #(
    parameter int unsigned  W       = 8,
    parameter logic [W-1:0] RST_VAL = 8'hA0,
    parameter int unsigned  MAX_DIV = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_stb,
    input  logic [1:0]   rate_sel,
    input  logic         cfg_wr,
    input  logic [W-1:0] cfg_wdata,
    output logic [W-1:0] cfg_rdata,
    input  logic         tap_in,
    output logic         win_open,
    output logic         single_tap,
    output logic         double_tap
);

    logic start, tick;

    tapwin_cfg #(.W(W), .RST_VAL(RST_VAL)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_data (cfg_wdata),
        .value   (cfg_rdata)
    );

    tapwin_prescale #(.MAX_DIV(MAX_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .run   (win_open),
        .stb   (smp_stb),
        .rate  (rate_sel),
        .tick  (tick)
    );

    tapwin_fsm #(.W(W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tap        (tap_in),
        .win_len    (cfg_rdata),
        .tick       (tick),
        .start      (start),
        .win_open   (win_open),
        .single_tap (single_tap),
        .double_tap (double_tap)
    );

endmodule

// File: rtl/tapwin_checker.sv
module tapwin_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tap_in,
    input logic [W-1:0] cfg_rdata,
    input logic         win_open,
    input logic         single_tap,
    input logic         double_tap
);

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(single_tap && double_tap));

    a_r11_single_width: assert property (@(posedge clk) disable iff (!rst_n)
        single_tap |=> !single_tap);

    a_r11_double_width: assert property (@(posedge clk) disable iff (!rst_n)
        double_tap |=> !double_tap);

    a_r8_double_cause: assert property (@(posedge clk) disable iff (!rst_n)
        double_tap |-> (!win_open && $past(win_open) && $past(tap_in)));

    a_r7_single_at_close: assert property (@(posedge clk) disable iff (!rst_n)
        single_tap |-> (!win_open && $past(win_open) && !$past(tap_in)));

    a_r3_open_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_open) |-> ($past(tap_in) && ($past(cfg_rdata) != '0)));

    a_r9_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_open && tap_in && (cfg_rdata == '0)) |=> !win_open);

endmodule

bind tapwin_timer tapwin_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tap_in     (tap_in),
    .cfg_rdata  (cfg_rdata),
    .win_open   (win_open),
    .single_tap (single_tap),
    .double_tap (double_tap)
);

// File: tb/tapwin_timer_bench.sv
`timescale 1ns/1ps
module tapwin_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_stb = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       tap_in = 1'b0;
    logic       win_open, single_tap, double_tap;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tapwin_timer u_tapwin_timer (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .rate_sel(rate_sel),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .tap_in(tap_in), .win_open(win_open),
        .single_tap(single_tap), .double_tap(double_tap)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_len(logic [7:0] v);
        cfg_wr = 1'b1; cfg_wdata = v; cyc(); cfg_wr = 1'b0;
    endtask

    task automatic tap_pulse();
        tap_in = 1'b1; cyc(); tap_in = 1'b0;
    endtask

    // one strobe, then one quiet cycle; flags summarise outputs after the strobe edge
    task automatic strobe(output bit opn, output bit sgl);
        smp_stb = 1'b1; cyc(); smp_stb = 1'b0;
        opn = win_open; sgl = single_tap;
        cyc();
    endtask

    task automatic t_reset();
        chk("R1 reg", cfg_rdata, 8'hA0);
        chk("R1 open", win_open, 0);
        chk("R1 reports", single_tap | double_tap, 0);
    endtask

    task automatic t_regio();
        write_len(8'h37);
        chk("R2 readback", cfg_rdata, 8'h37);
        write_len(8'hA0);
        chk("R2 restore", cfg_rdata, 8'hA0);
    endtask

    task automatic t_window(logic [1:0] rate, logic [7:0] len, int n, string req);
        bit opn, sgl, ok;
        rate_sel = rate;
        write_len(len);
        tap_pulse();
        chk("R3 open", win_open, 1);
        chk("R7 no report on first tap", single_tap, 0);
        ok = 1'b1;
        for (int i = 0; i < len * n - 1; i++) begin
            strobe(opn, sgl);
            if (!opn || sgl) ok = 1'b0;
        end
        chk({req, " open before last strobe"}, ok, 1);
        smp_stb = 1'b1; cyc(); smp_stb = 1'b0;
        chk({req, " closed"}, win_open, 0);
        chk("R7 single at close", single_tap, 1);
        cyc();
        chk("R11 single width", single_tap, 0);
    endtask

    task automatic t_double();
        bit opn, sgl, ok;
        rate_sel = 2'd0;
        write_len(8'd10);
        tap_pulse();
        for (int i = 0; i < 3; i++) strobe(opn, sgl);
        tap_in = 1'b1; cyc(); tap_in = 1'b0;
        chk("R8 double", double_tap, 1);
        chk("R8 closed", win_open, 0);
        chk("R11 exclusive", single_tap, 0);
        cyc();
        chk("R11 double width", double_tap, 0);
        ok = 1'b1;
        for (int i = 0; i < 12; i++) begin
            strobe(opn, sgl);
            if (opn || sgl) ok = 1'b0;
        end
        chk("R8 no later single", ok, 1);
    endtask

    task automatic t_zero();
        bit opn, sgl, ok;
        write_len(8'd0);
        tap_pulse();
        chk("R9 tap ignored", win_open, 0);
        ok = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tap_pulse();
            if (win_open || single_tap || double_tap) ok = 1'b0;
            strobe(opn, sgl);
            if (opn || sgl || double_tap) ok = 1'b0;
        end
        chk("R9 no report", ok, 1);
    endtask

    task automatic t_prescale_clear();
        bit opn, sgl, ok;
        rate_sel = 2'd2;
        write_len(8'd2);
        tap_pulse();
        strobe(opn, sgl);
        strobe(opn, sgl);
        tap_pulse();
        chk("R10 setup double", double_tap, 1);
        cyc();
        tap_in = 1'b1; smp_stb = 1'b1; cyc(); tap_in = 1'b0; smp_stb = 1'b0;
        chk("R10 reopened", win_open, 1);
        ok = 1'b1;
        for (int i = 0; i < 7; i++) begin
            strobe(opn, sgl);
            if (!opn || sgl) ok = 1'b0;
        end
        chk("R10 full first count", ok, 1);
        smp_stb = 1'b1; cyc(); smp_stb = 1'b0;
        chk("R10 closes on 8th strobe", single_tap, 1);
        cyc();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_regio();
        t_window(2'd0, 8'd5, 1, "R4");
        t_window(2'd1, 8'd3, 2, "R5");
        t_window(2'd2, 8'd4, 4, "R6");
        t_window(2'd3, 8'd2, 4, "R6 code3");
        t_window(2'd0, 8'hA0, 1, "R4 default len");
        t_double();
        t_zero();
        t_prescale_clear();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule